// File: doc/BRIEF.md
# Performance Event Counter Bank

This block is a small bank of 32-bit event counters of the kind a processor uses to profile its own activity. Each counter has a configuration word. The word chooses one line of a wide event vector and sets a group of freeze conditions. A counter advances by one on every clock in which its chosen event line is high and none of its freeze conditions holds. The freeze conditions depend on a stop bit in the counter itself, on the processor privilege level, on a per-process mark signal, and on a shared stop bit.

Software loads a counter with 0x80000000 minus the number of events it wants to wait for. The counter then reaches its top bit after exactly that many events. A shared control register does three things: it enables a level interrupt while any counter has its top bit set, it holds a stop bit for all counters, and it can ask the hardware to set that stop bit by itself at the moment a counter crosses into its top bit. Each counter also has a second configuration word. It is plain storage for software and has no effect on counting.

All registers sit on a simple read/write port. Reads return data one clock later. The counters, the interrupt level and the read data all come out of registers.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset, every counter reads 0 and every second configuration word reads 0. Every first configuration word reads 0x0000001F, with all five freeze bits set and event select 0. The shared control reads 0 and `irq` is 0.
- R2: `reg_addr[3:2]` selects the group and `reg_addr[1:0]` selects the counter index. Group 0 is the counter values, group 1 the first configuration words, group 2 the second configuration words, and group 3 index 0 the shared control. A read returns data on `reg_rdata` one clock after `reg_rd`, showing the state before any write in the same cycle. Unused addresses and unstored bits read 0.
- R3: First configuration word layout: bits [11:8] select the event line. A counter adds exactly 1 in each cycle where that line of `evt_in` is high and no freeze applies. It never adds more than 1 per clock.
- R4: First configuration word bit 0 stops its own counter. Shared control bit 0 stops all counters.
- R5: First configuration word bit 1 stops counting while `priv_sup` is 1. Bit 2 stops counting while `priv_sup` is 0.
- R6: First configuration word bit 3 stops counting while `mark_in` is 1. Bit 4 stops counting while `mark_in` is 0. This lets a held mark act as a start/stop gate.
- R7: A register write to a counter takes priority over an increment of that counter in the same cycle.
- R8: A counter that holds 0xFFFFFFFF stays there and does not wrap.
- R9: Shared control bit 1 enables the interrupt. `irq` is 1 in the cycle after any cycle where this bit is set and some counter has bit 31 set. It stays 1 until software clears those bits or the enable.
- R10: While shared control bit 2 is set, an increment that takes a counter from 0x7FFFFFFF to 0x80000000 also sets shared control bit 0 on the same edge. All counters then hold until software clears bit 0.
- R11: The second configuration words store all 32 bits and have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_EVENTS | Event lines, sampled every clock |
| priv_sup | input | 1 | 1 while the processor runs in supervisor mode |
| mark_in | input | 1 | Mark state of the running process |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address (group, index) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after `reg_rd` |
| irq | output | 1 | Level interrupt, registered |

## Verification
Suppose a freeze term is decoded wrongly, or the event select is off by one line. The counter value then differs from the bench's model after the first affected event. The error shows at the next read of that counter, which returns it one clock later. A wrong shared freeze or a wrong overflow trigger spreads into every enabled counter's value, and into `irq` one cycle after the top bit changes. A wrong interrupt term shows on `irq` itself, which is compared on every clock.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int IDX_W    = 2;

  localparam logic [1:0] GRP_CNT  = 2'd0;
  localparam logic [1:0] GRP_CFGA = 2'd1;
  localparam logic [1:0] GRP_CFGB = 2'd2;
  localparam logic [1:0] GRP_GLB  = 2'd3;

  localparam int A_STOP    = 0;
  localparam int A_NO_SUP  = 1;
  localparam int A_NO_USR  = 2;
  localparam int A_NO_MK1  = 3;
  localparam int A_NO_MK0  = 4;
  localparam int A_SEL_LSB = 8;

  typedef struct packed {
    logic ovf_stop;
    logic irq_en;
    logic stop_all;
  } glb_t;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int NUM_EVENTS = 16,
  parameter int SEL_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVENTS-1:0] evt_in,
  input  logic                  priv_sup,
  input  logic                  mark_in,
  input  logic                  glb_stop,
  input  logic                  wr_cnt,
  input  logic                  wr_cfga,
  input  logic                  wr_cfgb,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     cnt_q,
  output logic [DATA_W-1:0]     cfga_q,
  output logic [DATA_W-1:0]     cfgb_q,
  output logic                  ovf_hit
);
  localparam int EVT_SPAN = 1 << SEL_W;

  logic             stop_q, no_sup_q, no_usr_q, no_mk1_q, no_mk0_q;
  logic [SEL_W-1:0] sel_q;
  logic [EVT_SPAN-1:0] evt_ext;
  logic evt_hit, frozen, at_max, bump;

  always_comb begin
    evt_ext = '0;
    evt_ext[NUM_EVENTS-1:0] = evt_in;
  end

  assign evt_hit = evt_ext[sel_q];
  assign frozen  = stop_q | glb_stop
                 | (priv_sup & no_sup_q) | (~priv_sup & no_usr_q)
                 | (mark_in & no_mk1_q)  | (~mark_in & no_mk0_q);
  assign at_max  = &cnt_q;
  assign bump    = evt_hit & ~frozen & ~at_max;
  assign ovf_hit = bump & ~cnt_q[DATA_W-1] & (&cnt_q[DATA_W-2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata;
    end else if (bump) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q   <= 1'b1;
      no_sup_q <= 1'b1;
      no_usr_q <= 1'b1;
      no_mk1_q <= 1'b1;
      no_mk0_q <= 1'b1;
      sel_q    <= '0;
      cfgb_q   <= '0;
    end else begin
      if (wr_cfga) begin
        stop_q   <= wdata[A_STOP];
        no_sup_q <= wdata[A_NO_SUP];
        no_usr_q <= wdata[A_NO_USR];
        no_mk1_q <= wdata[A_NO_MK1];
        no_mk0_q <= wdata[A_NO_MK0];
        sel_q    <= wdata[A_SEL_LSB +: SEL_W];
      end
      if (wr_cfgb) begin
        cfgb_q <= wdata;
      end
    end
  end

  always_comb begin
    cfga_q = '0;
    cfga_q[A_STOP]   = stop_q;
    cfga_q[A_NO_SUP] = no_sup_q;
    cfga_q[A_NO_USR] = no_usr_q;
    cfga_q[A_NO_MK1] = no_mk1_q;
    cfga_q[A_NO_MK0] = no_mk0_q;
    cfga_q[A_SEL_LSB +: SEL_W] = sel_q;
  end

  a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt_q == $past(wdata));

  a_r4_frozen_holds: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && frozen) |=> cnt_q == $past(cnt_q));

  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && at_max) |=> &cnt_q);

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    !wr_cnt |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 32'd1));

  a_r3_no_evt_no_step: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && !evt_hit) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/pmu_global_ctl.sv
module pmu_global_ctl
  import pmu_pkg::*;
#(
  parameter int NUM_CTRS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_glb,
  input  logic [2:0]          wdata,
  input  logic [NUM_CTRS-1:0] msb_vec,
  input  logic [NUM_CTRS-1:0] ovf_vec,
  output glb_t                glb_q,
  output logic                irq
);
  logic trig;
  glb_t glb_nxt;

  assign trig = glb_q.ovf_stop & (|ovf_vec);

  always_comb begin
    glb_nxt = wr_glb ? glb_t'(wdata) : glb_q;
    if (trig) glb_nxt.stop_all = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_q <= '0;
      irq   <= 1'b0;
    end else begin
      glb_q <= glb_nxt;
      irq   <= glb_q.irq_en & (|msb_vec);
    end
  end

  a_r10_ovf_freezes: assert property (@(posedge clk) disable iff (rst)
    trig |=> glb_q.stop_all);

  a_r9_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (glb_q.irq_en && (|msb_vec)) |=> irq);

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (!glb_q.irq_en || !(|msb_vec)) |=> !irq);
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
  import pmu_pkg::*;
#(
  parameter int NUM_CTRS   = 4,
  parameter int NUM_EVENTS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVENTS-1:0] evt_in,
  input  logic                  priv_sup,
  input  logic                  mark_in,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [3:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  irq
);
  localparam int SEL_W = $clog2(NUM_EVENTS);

  logic [1:0]       grp;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] cnt_arr  [NUM_CTRS];
  logic [DATA_W-1:0] cfga_arr [NUM_CTRS];
  logic [DATA_W-1:0] cfgb_arr [NUM_CTRS];
  logic [NUM_CTRS-1:0] msb_vec, ovf_vec;
  glb_t glb_q;
  logic [DATA_W-1:0] rd_mux;

  assign grp = reg_addr[3:2];
  assign idx = reg_addr[1:0];

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
    logic sel_me;
    assign sel_me = reg_wr && (idx == IDX_W'(i));
    pmu_counter #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) ctr_i (
      .clk      (clk),
      .rst      (rst),
      .evt_in   (evt_in),
      .priv_sup (priv_sup),
      .mark_in  (mark_in),
      .glb_stop (glb_q.stop_all),
      .wr_cnt   (sel_me && grp == GRP_CNT),
      .wr_cfga  (sel_me && grp == GRP_CFGA),
      .wr_cfgb  (sel_me && grp == GRP_CFGB),
      .wdata    (reg_wdata),
      .cnt_q    (cnt_arr[i]),
      .cfga_q   (cfga_arr[i]),
      .cfgb_q   (cfgb_arr[i]),
      .ovf_hit  (ovf_vec[i])
    );
    assign msb_vec[i] = cnt_arr[i][DATA_W-1];
  end

  pmu_global_ctl #(.NUM_CTRS(NUM_CTRS)) glb_i (
    .clk     (clk),
    .rst     (rst),
    .wr_glb  (reg_wr && grp == GRP_GLB && idx == '0),
    .wdata   (reg_wdata[2:0]),
    .msb_vec (msb_vec),
    .ovf_vec (ovf_vec),
    .glb_q   (glb_q),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (grp == GRP_GLB) begin
      if (idx == '0) rd_mux = {29'd0, glb_q};
    end else begin
      for (int i = 0; i < NUM_CTRS; i++) begin
        if (idx == IDX_W'(i)) begin
          case (grp)
            GRP_CNT:  rd_mux = cnt_arr[i];
            GRP_CFGA: rd_mux = cfga_arr[i];
            default:  rd_mux = cfgb_arr[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  a_r2_read_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/pmu_counter_bank_tb_top.sv
module pmu_counter_bank_tb_top;
  localparam int NC = 4;
  localparam int NE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NE-1:0] evt_in = '0;
  logic priv_sup = 1'b0, mark_in = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  always #4 clk = ~clk;

  pmu_counter_bank #(.NUM_CTRS(NC), .NUM_EVENTS(NE)) dut_i (
    .clk(clk), .rst(rst), .evt_in(evt_in), .priv_sup(priv_sup), .mark_in(mark_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  logic [31:0] m_cnt [NC];
  logic [31:0] m_a   [NC];
  logic [31:0] m_b   [NC];
  logic [2:0]  m_g;
  logic        m_irq;
  logic [31:0] m_rd;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a[3:2])
      2'd0: return m_cnt[a[1:0]];
      2'd1: return m_a[a[1:0]];
      2'd2: return m_b[a[1:0]];
      default: return (a[1:0] == 2'd0) ? {29'd0, m_g} : 32'd0;
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] nc [NC];
    logic any_msb, any_ovf, f, inc;
    logic [2:0] ng;
    if (rst) begin
      for (int i = 0; i < NC; i++) begin
        m_cnt[i] = 0; m_a[i] = 32'h1F; m_b[i] = 0;
      end
      m_g = 0; m_irq = 0; m_rd = 0;
      return;
    end
    any_msb = 0; any_ovf = 0;
    for (int i = 0; i < NC; i++) begin
      any_msb |= m_cnt[i][31];
      f = m_a[i][0] | m_g[0] | (priv_sup & m_a[i][1]) | (!priv_sup & m_a[i][2])
        | (mark_in & m_a[i][3]) | (!mark_in & m_a[i][4]);
      inc = evt_in[m_a[i][11:8]] && !f && (m_cnt[i] != 32'hFFFF_FFFF);
      if (inc && m_cnt[i] == 32'h7FFF_FFFF) any_ovf = 1;
      nc[i] = m_cnt[i] + {31'd0, inc};
    end
    if (reg_rd) m_rd = m_read(reg_addr);
    ng = m_g;
    if (reg_wr) begin
      case (reg_addr[3:2])
        2'd0: nc[reg_addr[1:0]] = reg_wdata;
        2'd1: m_a[reg_addr[1:0]] = reg_wdata & 32'h0000_0F1F;
        2'd2: m_b[reg_addr[1:0]] = reg_wdata;
        default: if (reg_addr[1:0] == 2'd0) ng = reg_wdata[2:0];
      endcase
    end
    if (m_g[2] && any_ovf) ng[0] = 1'b1;
    m_irq = m_g[1] & any_msb;
    m_g = ng;
    for (int i = 0; i < NC; i++) m_cnt[i] = nc[i];
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_chk(logic [3:0] a, string tag, logic [31:0] exp);
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(logic [NE-1:0] e, int n);
    evt_in = e;
    for (int k = 0; k < n; k++) tick();
    evt_in = '0;
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    for (int k = 0; k < 4; k++) tick();
    rst = 0;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int i = 0; i < NC; i++) begin
      rd_chk(4'(i), "R1 counter", 32'd0);
      rd_chk(4'(4 + i), "R1 cfgA", 32'h1F);
      rd_chk(4'(8 + i), "R1 cfgB", 32'd0);
    end
    rd_chk(4'd12, "R1 global", 32'd0);
    // R2 register access
    for (int i = 0; i < NC; i++) wr(4'(i), 32'h1000_0000 + i);
    for (int i = 0; i < NC; i++) rd_chk(4'(i), "R2 counter rw", 32'h1000_0000 + i);
    wr(4'd8, 32'hDEAD_BEEF);
    rd_chk(4'd8, "R2 cfgB rw", 32'hDEAD_BEEF);
    wr(4'd12, 32'hFFFF_FFF8);
    rd_chk(4'd12, "R2 global unstored bits", 32'd0);
    rd_chk(4'd13, "R2 unused addr", 32'd0);
    wr(4'd5, 32'hFFFF_FFFF);
    rd_chk(4'd5, "R2 cfgA stored bits", 32'h0000_0F1F);
    // R3 event select and counting
    wr(4'd4, 32'h300); wr(4'd0, 0);
    wr(4'd5, 32'h200); wr(4'd1, 0);
    wr(4'd2, 0);
    pulse(16'h000C, 5);
    rd_chk(4'd0, "R3 ctr0 sel3", 32'd5);
    rd_chk(4'd1, "R3 ctr1 sel2", 32'd5);
    rd_chk(4'd2, "R3 ctr2 frozen by reset cfg", 32'd0);
    pulse(16'h0010, 2);
    rd_chk(4'd0, "R3 other line ignored", 32'd5);
    // R11 second config word has no effect
    wr(4'd8, 32'hFFFF_FFFF);
    pulse(16'h0008, 1);
    rd_chk(4'd0, "R11 cfgB no effect", 32'd6);
    // R4 stop bits
    wr(4'd4, 32'h301);
    pulse(16'h0008, 3);
    rd_chk(4'd0, "R4 local stop", 32'd6);
    wr(4'd4, 32'h300);
    wr(4'd12, 32'd1);
    pulse(16'h0008, 3);
    rd_chk(4'd0, "R4 global stop", 32'd6);
    wr(4'd12, 32'd0);
    pulse(16'h0008, 1);
    rd_chk(4'd0, "R4 resume", 32'd7);
    // R5 privilege freezes
    wr(4'd4, 32'h302);
    priv_sup = 1; pulse(16'h0008, 2);
    priv_sup = 0; pulse(16'h0008, 2);
    rd_chk(4'd0, "R5 freeze in supervisor", 32'd9);
    wr(4'd4, 32'h304);
    pulse(16'h0008, 2);
    priv_sup = 1; pulse(16'h0008, 2);
    priv_sup = 0;
    rd_chk(4'd0, "R5 freeze in user", 32'd11);
    // R6 mark gating
    wr(4'd4, 32'h308);
    mark_in = 1; pulse(16'h0008, 2);
    mark_in = 0; pulse(16'h0008, 3);
    rd_chk(4'd0, "R6 freeze on mark high", 32'd14);
    wr(4'd4, 32'h310);
    pulse(16'h0008, 2);
    mark_in = 1; pulse(16'h0008, 1);
    mark_in = 0;
    rd_chk(4'd0, "R6 freeze on mark low", 32'd15);
    wr(4'd4, 32'h300);
    // R7 write beats increment
    evt_in = 16'h0008;
    wr(4'd0, 32'd100);
    evt_in = 0;
    rd_chk(4'd0, "R7 write priority", 32'd100);
    // R8 saturation
    wr(4'd0, 32'hFFFF_FFFF);
    pulse(16'h0008, 3);
    rd_chk(4'd0, "R8 saturate", 32'hFFFF_FFFF);
    // R9 interrupt
    wr(4'd0, 32'h7FFF_FFFE);
    wr(4'd12, 32'd2);
    chk("R9 irq low before overflow", {31'd0, irq}, 32'd0);
    evt_in = 16'h0008;
    tick(); chk("R9 irq at 7FFFFFFF", {31'd0, irq}, 32'd0);
    tick(); chk("R9 irq lags top bit", {31'd0, irq}, 32'd0);
    evt_in = 0;
    tick(); chk("R9 irq raised", {31'd0, irq}, 32'd1);
    tick(); chk("R9 irq held", {31'd0, irq}, 32'd1);
    wr(4'd0, 32'd0);
    chk("R9 irq one cycle after clear", {31'd0, irq}, 32'd1);
    tick(); chk("R9 irq cleared", {31'd0, irq}, 32'd0);
    // R10 freeze on overflow
    wr(4'd0, 32'h7FFF_FFFE);
    wr(4'd12, 32'd6);
    pulse(16'h000C, 4);
    rd_chk(4'd0, "R10 ctr0 stops at top", 32'h8000_0000);
    rd_chk(4'd1, "R10 ctr1 stopped too", 32'd7);
    rd_chk(4'd12, "R10 global stop set", 32'd7);
    wr(4'd12, 32'd2);
    pulse(16'h0008, 1);
    rd_chk(4'd0, "R10 resume after clear", 32'h8000_0001);
    // random phase, all requirements against the model
    for (int c = 0; c < 6000; c++) begin
      logic was_rd;
      evt_in   = NE'($urandom);
      priv_sup = 1'($urandom);
      mark_in  = 1'($urandom);
      reg_rd   = 1'($urandom);
      reg_addr = 4'($urandom);
      reg_wr   = ($urandom % 6) == 0;
      case ($urandom % 4)
        0: reg_wdata = 32'h7FFF_FFF0 + ($urandom % 16);
        1: reg_wdata = 32'hFFFF_FFF0 + ($urandom % 16);
        2: reg_wdata = $urandom & 32'h0000_0F06;
        default: reg_wdata = $urandom;
      endcase
      if (reg_addr == 4'd12) reg_wdata = $urandom & 32'h6;
      was_rd = reg_rd;
      tick();
      reg_wr = 0; reg_rd = 0;
      if (was_rd) chk("R2 random read", reg_rdata, m_rd);
      chk("R9 random irq", {31'd0, irq}, {31'd0, m_irq});
    end
    for (int a = 0; a < 16; a++) begin
      logic [31:0] e;
      e = m_read(4'(a));
      rd_chk(4'(a), "R3 final state", e);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule